// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by walking a four-level radix table held in memory. A walk starts from a per-process root page number, reads one 64-bit entry per level through a single-word memory port and uses the physical base in each entry to find the next table. The low 12 bits of the virtual address pass straight into the result. The upper 36 bits are four 9-bit indices; the first index selects the entry in the root table.

Every request carries an access kind (read, write or instruction fetch) and a user/supervisor flag. At each level the walker checks that the entry is present and that the entry grants the access. It stops at the first level that fails, so the access is granted only when all four levels allow it. Each entry that passes gets its Accessed flag set in memory, and the leaf also gets its Dirty flag on a write. This is a read-modify-write that the walker issues only when a flag actually changes. The walk ends with a one-cycle reply that holds either the physical address or a fault code.

The controller has six states. IDLE accepts a request and goes to FETCH_REQ. FETCH_REQ issues the entry read and goes to FETCH_WAIT. When the read completes, FETCH_WAIT goes to one of three places. It goes to REPLY on a fault. It goes to MARK_REQ when a flag must be written back. Otherwise it advances: to FETCH_REQ of the next level, or to REPLY after the leaf. MARK_REQ issues the write and goes to MARK_WAIT. On the write completion, MARK_WAIT advances in the same way. REPLY pulses the response and returns to IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: The first entry is read at {root_ppn, VA[47:39], 3'b000}. Each later level reads at {PPN of the previous entry (entry bits 51:12), next 9-bit index, 3'b000}, with the indices taken from VA[38:30], VA[29:21] and VA[20:12] in that order.
- R2: A successful walk replies with rsp_fault = 0 and rsp_paddr = {leaf entry bits 51:12, VA[11:0]}.
- R3: If an entry has bit 0 (present) clear at any level, the walk stops with rsp_fault = 1 and rsp_paddr = 0. That entry is not written and no deeper level is read.
- R4: A write (req_kind = 1) through any entry with bit 1 (writable) clear stops the walk with rsp_fault = 2 and leaves that entry unwritten.
- R5: A user access (req_user = 1) through any entry with bit 2 (user-allowed) clear stops the walk with rsp_fault = 2. The same path succeeds for a supervisor access.
- R6: A fetch (req_kind = 2) through any entry with bit 63 (no-execute) set stops the walk with rsp_fault = 2. A read through the same path succeeds. req_kind = 3 acts as a read.
- R7: Each entry that passes its checks has bit 5 (accessed) set in memory. The walker does this with a write of the entry value plus the flag to the same address, issued right after the read, and only when the flag changes the word.
- R8: On a write access the leaf entry also gets bit 6 (dirty) set, in the same write-back as bit 5. Non-leaf entries and non-write accesses never get bit 6 set.
- R9: Each walk produces exactly one rsp_valid pulse, one cycle long. Fault codes are 0 (none), 1 (not present) and 2 (protection).
- R10: A request is accepted only while busy is low. req_valid asserted while busy is high is ignored.
- R11: After reset, busy, rsp_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_vaddr | input | 48 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-level access |
| root_ppn | input | 40 | Page number of the first-level table |
| busy | output | 1 | High from acceptance through the reply cycle |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | Qualifies mem_req as a write |
| mem_addr | output | 52 | Byte address of the entry |
| mem_wdata | output | 64 | Entry value to write back |
| mem_ack | input | 1 | Completion of the outstanding access |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_paddr | output | 52 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | Fault code |

## Verification
The assertions check the following on every cycle:
- each walk begins with a read at the root table;
- every write-back follows a read completion, targets the address just read, and carries the accessed flag;
- memory strobes and replies last one cycle;
- a faulting reply never carries an address;
- a walk starts only on a request.

Some properties span the whole table and show only in the bench's scenarios, because the bench models memory:
- which entries get the accessed or dirty flags, and how many write-backs a walk costs;
- that the level where a check fails decides the fault;
- that a request made while busy leaves the reply unchanged.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    // Entry flag positions; software and the walker share this layout.
    localparam int FLAG_PRESENT  = 0;
    localparam int FLAG_WRITABLE = 1;
    localparam int FLAG_USER     = 2;
    localparam int FLAG_ACCESSED = 5;
    localparam int FLAG_DIRTY    = 6;
    localparam int FLAG_NOEXEC   = 63;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_MARK_REQ,
        ST_MARK_WAIT,
        ST_REPLY
    } walk_state_e;

endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int SLOT_SH = OFF_W - IDX_W
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    input  logic [PPN_W-1:0] base_ppn,
    output logic [PA_W-1:0]  entry_addr
);

    logic [IDX_W-1:0] idx_tab [LEVELS];

    // Level 0 takes the most significant index field.
    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        assign idx_tab[l] = vaddr[OFF_W + (LEVELS - 1 - l) * IDX_W +: IDX_W];
    end

    // The offset field is kept whole so all address bits are consumed.
    logic [OFF_W-1:0] unused_off;
    assign unused_off = vaddr[OFF_W-1:0];

    assign entry_addr = {base_ppn, idx_tab[level], {SLOT_SH{1'b0}}};

endmodule

// File: rtl/pgwalk_entry_check.sv
module pgwalk_entry_check
    import pgwalk_pkg::*;
#(
    parameter int ENTRY_W = 64,
    parameter int PA_W    = 52,
    parameter int OFF_W   = 12,
    localparam int PPN_W  = PA_W - OFF_W
) (
    input  logic [ENTRY_W-1:0] entry,
    input  acc_kind_e          kind,
    input  logic               is_user,
    input  logic               is_leaf,
    output logic               present,
    output logic               allowed,
    output logic               need_mark,
    output logic [ENTRY_W-1:0] marked_entry,
    output logic [PPN_W-1:0]   next_ppn
);

    always_comb begin
        present = entry[FLAG_PRESENT];

        allowed = 1'b1;
        if (kind == ACC_WRITE && !entry[FLAG_WRITABLE]) allowed = 1'b0;
        if (is_user && !entry[FLAG_USER])                allowed = 1'b0;
        if (kind == ACC_FETCH && entry[FLAG_NOEXEC])    allowed = 1'b0;

        marked_entry = entry;
        marked_entry[FLAG_ACCESSED] = 1'b1;
        if (is_leaf && kind == ACC_WRITE) marked_entry[FLAG_DIRTY] = 1'b1;

        need_mark = (marked_entry != entry);
        next_ppn  = entry[PA_W-1:OFF_W];
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int PA_W    = 52,
    parameter int IDX_W   = 9,
    parameter int OFF_W   = 12,
    parameter int LEVELS  = 4,
    parameter int ENTRY_W = 64,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int LAST   = LEVELS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [PPN_W-1:0]   root_ppn,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic               mem_ack,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault
);

    walk_state_e        state_q,  state_d;
    logic [LVL_W-1:0]   level_q,  level_d;
    logic [PPN_W-1:0]   base_q,   base_d;
    logic [VA_W-1:0]    vaddr_q,  vaddr_d;
    acc_kind_e          kind_q,   kind_d;
    logic               user_q,   user_d;
    logic [ENTRY_W-1:0] entry_q,  entry_d;
    logic [PA_W-1:0]    paddr_q,  paddr_d;
    fault_e             fault_q,  fault_d;

    logic               is_leaf;
    logic               chk_present, chk_allowed, chk_need_mark;
    logic [ENTRY_W-1:0] chk_marked;
    logic [PPN_W-1:0]   chk_next_ppn;
    logic [PPN_W-1:0]   adv_ppn;
    logic               do_adv;
    logic [PA_W-1:0]    slot_addr;

    assign is_leaf = (level_q == LVL_W'(LAST));

    pgwalk_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
    ) u_addr (
        .vaddr      (vaddr_q),
        .level      (level_q),
        .base_ppn   (base_q),
        .entry_addr (slot_addr)
    );

    pgwalk_entry_check #(
        .ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_check (
        .entry        (mem_rdata),
        .kind         (kind_q),
        .is_user      (user_q),
        .is_leaf      (is_leaf),
        .present      (chk_present),
        .allowed      (chk_allowed),
        .need_mark    (chk_need_mark),
        .marked_entry (chk_marked),
        .next_ppn     (chk_next_ppn)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        base_d  = base_q;
        vaddr_d = vaddr_q;
        kind_d  = kind_q;
        user_d  = user_q;
        entry_d = entry_q;
        paddr_d = paddr_q;
        fault_d = fault_q;
        do_adv  = 1'b0;
        adv_ppn = entry_q[PA_W-1:OFF_W];

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_FETCH_REQ;
                    level_d = '0;
                    base_d  = root_ppn;
                    vaddr_d = req_vaddr;
                    kind_d  = (req_kind == 2'd3) ? ACC_READ : acc_kind_e'(req_kind);
                    user_d  = req_user;
                end
            end
            ST_FETCH_REQ: state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: begin
                if (mem_ack) begin
                    entry_d = chk_marked;
                    adv_ppn = chk_next_ppn;
                    if (!chk_present) begin
                        fault_d = FLT_ABSENT;
                        paddr_d = '0;
                        state_d = ST_REPLY;
                    end else if (!chk_allowed) begin
                        fault_d = FLT_PROT;
                        paddr_d = '0;
                        state_d = ST_REPLY;
                    end else if (chk_need_mark) begin
                        state_d = ST_MARK_REQ;
                    end else begin
                        do_adv = 1'b1;
                    end
                end
            end
            ST_MARK_REQ: state_d = ST_MARK_WAIT;
            ST_MARK_WAIT: begin
                if (mem_ack) do_adv = 1'b1;
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase

        if (do_adv) begin
            if (is_leaf) begin
                fault_d = FLT_NONE;
                paddr_d = {adv_ppn, vaddr_q[OFF_W-1:0]};
                state_d = ST_REPLY;
            end else begin
                level_d = level_q + LVL_W'(1);
                base_d  = adv_ppn;
                state_d = ST_FETCH_REQ;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            base_q  <= '0;
            vaddr_q <= '0;
            kind_q  <= ACC_READ;
            user_q  <= 1'b0;
            entry_q <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            base_q  <= base_d;
            vaddr_q <= vaddr_d;
            kind_q  <= kind_d;
            user_q  <= user_d;
            entry_q <= entry_d;
            paddr_q <= paddr_d;
            fault_q <= fault_d;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = (state_q == ST_FETCH_REQ) || (state_q == ST_MARK_REQ);
        mem_we    = (state_q == ST_MARK_REQ);
        mem_addr  = slot_addr;
        mem_wdata = entry_q;
        rsp_valid = (state_q == ST_REPLY);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
    end

    // Assertions
    assert_root_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && mem_addr[PA_W-1:OFF_W] == $past(root_ppn)));

    assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_fault_no_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    assert_mark_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_ack) && mem_wdata[FLAG_ACCESSED]));

    assert_mark_same_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == $past(mem_addr)));

    assert_reply_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));

    assert_start_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [39:0] root_ppn = 40'd4;
    logic        busy, mem_req, mem_we, mem_ack = 1'b0;
    logic [51:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata = '0;
    logic        rsp_valid;
    logic [51:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    always #2.5 clk = ~clk;

    pgwalk_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .root_ppn(root_ppn),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    localparam logic [11:0] P = 12'h001, W = 12'h002, U = 12'h004, A = 12'h020, D = 12'h040;

    function automatic logic [63:0] mk(logic [39:0] ppn, logic [11:0] fl, logic nx);
        return {nx, 11'b0, ppn, fl};
    endfunction

    function automatic logic [47:0] mkva(logic [8:0] a, logic [8:0] b, logic [8:0] c,
                                         logic [8:0] d, logic [11:0] off);
        return {a, b, c, d, off};
    endfunction

    function automatic int wi(int ppn, int idx);
        return (ppn % 8) * 32 + idx;
    endfunction

    typedef struct packed {
        logic [47:0] va;
        logic [1:0]  kind;
        logic        user;
        logic [1:0]  flt;
        logic [51:0] pa;
        logic [3:0]  wr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{mkva(0,0,0,0,12'h123), 2'd0, 1'b1, 2'd0, 52'hABCDE123, 4'd2, 4'd2},  // R2 R7
        '{mkva(0,0,0,0,12'hFFF), 2'd1, 1'b1, 2'd0, 52'hABCDEFFF, 4'd2, 4'd8},  // R8 A+D one write
        '{mkva(0,0,0,1,12'h000), 2'd0, 1'b1, 2'd0, 52'h12345000, 4'd1, 4'd7},  // R7 leaf already marked
        '{mkva(0,0,0,1,12'h004), 2'd1, 1'b1, 2'd0, 52'h12345004, 4'd1, 4'd8},  // R8 dirty already set
        '{mkva(0,0,0,2,12'h456), 2'd1, 1'b1, 2'd0, 52'h00777456, 4'd2, 4'd8},  // R8 dirty only
        '{mkva(1,0,0,0,12'h000), 2'd0, 1'b1, 2'd1, 52'h0,        4'd0, 4'd3},  // R3 top level
        '{mkva(0,0,1,0,12'h000), 2'd0, 1'b1, 2'd1, 52'h0,        4'd1, 4'd3},  // R3 third level
        '{mkva(2,0,0,0,12'h000), 2'd1, 1'b1, 2'd2, 52'h0,        4'd0, 4'd4},  // R4
        '{mkva(2,0,0,0,12'h010), 2'd0, 1'b1, 2'd0, 52'hABCDE010, 4'd2, 4'd4},  // R4 read allowed
        '{mkva(3,0,0,0,12'h000), 2'd0, 1'b1, 2'd2, 52'h0,        4'd0, 4'd5},  // R5
        '{mkva(3,0,0,0,12'h005), 2'd0, 1'b0, 2'd0, 52'hABCDE005, 4'd2, 4'd5},  // R5 supervisor ok
        '{mkva(4,0,0,0,12'h000), 2'd2, 1'b1, 2'd2, 52'h0,        4'd0, 4'd6},  // R6 top-level no-exec
        '{mkva(4,0,0,0,12'h007), 2'd3, 1'b1, 2'd0, 52'hABCDE007, 4'd2, 4'd6},  // R6 kind 3 reads
        '{mkva(0,0,0,3,12'h008), 2'd2, 1'b1, 2'd2, 52'h0,        4'd1, 4'd6},  // R6 leaf no-exec
        '{mkva(0,0,0,0,12'h009), 2'd2, 1'b1, 2'd0, 52'hABCDE009, 4'd2, 4'd6}   // R6 fetch ok
    };

    logic [63:0] mem [256];
    int wr_cnt = 0, bad_cnt = 0;
    int tests = 0, fails = 0;
    bit done = 1'b0;
    int rsp_cnt;
    logic [51:0] got_pa;
    logic [1:0]  got_flt;

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[wi(4,0)] = mk(40'd5, P|W|U, 1'b0);
        mem[wi(4,2)] = mk(40'd5, P|U, 1'b0);
        mem[wi(4,3)] = mk(40'd5, P|W, 1'b0);
        mem[wi(4,4)] = mk(40'd5, P|W|U, 1'b1);
        mem[wi(5,0)] = mk(40'd6, P|W|U|A, 1'b0);
        mem[wi(6,0)] = mk(40'd7, P|W|U|A, 1'b0);
        mem[wi(7,0)] = mk(40'hABCDE, P|W|U, 1'b0);
        mem[wi(7,1)] = mk(40'h12345, P|W|U|A|D, 1'b0);
        mem[wi(7,2)] = mk(40'h00777, P|W|U|A, 1'b0);
        mem[wi(7,3)] = mk(40'h00055, P|W|U|A, 1'b1);
    endtask

    // Memory model: acknowledges one negedge after the strobe is seen.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                logic [51:0] a;
                logic        we;
                logic [63:0] wd;
                int          k;
                a  = mem_addr;
                we = mem_we;
                wd = mem_wdata;
                if (a[51:15] != '0 || a[11:8] != '0 || a[2:0] != '0) bad_cnt++;
                k = int'(a[14:12]) * 32 + int'(a[7:3]);
                @(negedge clk);
                if (we) begin
                    mem[k] = wd;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[k];
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic walk(input logic [47:0] va, input logic [1:0] kind, input logic user,
                        input bit poke_busy);
        int guard;
        bit seen;
        @(negedge clk);
        wr_cnt   = 0;
        rsp_cnt  = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = kind;
        req_user  = user;
        @(negedge clk);
        req_valid = 1'b0;
        seen  = 1'b0;
        guard = 0;
        while (guard < 200) begin
            if (poke_busy && guard == 2) begin
                req_valid = 1'b1;
                req_vaddr = mkva(1,0,0,0,12'h000);
                req_kind  = 2'd1;
            end
            if (poke_busy && guard == 3) req_valid = 1'b0;
            if (rsp_valid) begin
                rsp_cnt++;
                got_pa  = rsp_paddr;
                got_flt = rsp_fault;
                seen    = 1'b1;
            end
            if (seen && !busy) break;
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !rsp_valid && !mem_req, "R11", "reset outputs",
              {busy, rsp_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !rsp_valid && !mem_req, "R11", "idle after reset",
              {busy, rsp_valid, mem_req}, 0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].rq);
            init_mem();
            walk(VECS[v].va, VECS[v].kind, VECS[v].user, 1'b0);
            check(rsp_cnt == 1, "R9", $sformatf("vec %0d reply count", v), rsp_cnt, 1);
            check(got_flt == VECS[v].flt, tag, $sformatf("vec %0d fault", v), got_flt, VECS[v].flt);
            check(got_pa == VECS[v].pa, tag, $sformatf("vec %0d paddr", v), got_pa, VECS[v].pa);
            check(wr_cnt == int'(VECS[v].wr), "R7", $sformatf("vec %0d write-backs", v),
                  wr_cnt, VECS[v].wr);
        end

        // R8: flags in memory after a write walk
        init_mem();
        walk(mkva(0,0,0,0,12'h000), 2'd1, 1'b1, 1'b0);
        check(mem[wi(7,0)] == mk(40'hABCDE, P|W|U|A|D, 1'b0), "R8", "leaf flags after write",
              mem[wi(7,0)], mk(40'hABCDE, P|W|U|A|D, 1'b0));
        check(mem[wi(4,0)] == mk(40'd5, P|W|U|A, 1'b0), "R8", "top entry accessed only",
              mem[wi(4,0)], mk(40'd5, P|W|U|A, 1'b0));

        // R8: a read leaves dirty clear at the leaf
        init_mem();
        walk(mkva(0,0,0,0,12'h000), 2'd0, 1'b1, 1'b0);
        check(mem[wi(7,0)] == mk(40'hABCDE, P|W|U|A, 1'b0), "R8", "leaf flags after read",
              mem[wi(7,0)], mk(40'hABCDE, P|W|U|A, 1'b0));

        // R3/R4: faulting entries are not written
        init_mem();
        walk(mkva(2,0,0,0,12'h000), 2'd1, 1'b1, 1'b0);
        check(mem[wi(4,2)] == mk(40'd5, P|U, 1'b0), "R4", "read-only entry untouched",
              mem[wi(4,2)], mk(40'd5, P|U, 1'b0));

        // R1: a different root base reaches an empty table
        init_mem();
        root_ppn = 40'd3;
        walk(mkva(0,0,0,0,12'h000), 2'd0, 1'b1, 1'b0);
        check(got_flt == 2'd1, "R1", "root base selects table", got_flt, 1);
        root_ppn = 40'd4;

        // R10: request during a walk is ignored
        init_mem();
        walk(mkva(0,0,0,0,12'h001), 2'd0, 1'b1, 1'b1);
        check(rsp_cnt == 1, "R10", "one reply despite extra request", rsp_cnt, 1);
        check(got_pa == 52'hABCDE001 && got_flt == 2'd0, "R10", "reply from first request",
              got_pa, 52'hABCDE001);
        repeat (4) @(negedge clk);
        check(!busy && !rsp_valid, "R10", "no second walk started", {busy, rsp_valid}, 0);

        check(bad_cnt == 0, "R1", "entry addresses well formed", bad_cnt, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule